// File: doc/BRIEF.md
# Paging Address Codeword Matcher

This block sits behind a bit-synchronised paging receiver and its error-correction stage. The receiver hands it one 32-bit codeword at a time, together with the index (0 to 7) of the frame slot the codeword occupies in its batch and a flag saying that the upstream syndrome check passed. The matcher tests every address codeword against a bank of four programmable identifiers. When one of them matches, it raises a one-clock hit strobe and reports the index of that identifier.

Each identifier has a type bit. A receiver-code identifier matches an 18-bit pattern, and only in the frame slot named by its 3 stored frame bits. A sync-word identifier matches the same 18-bit pattern in any slot. A global control bit can switch off the two lowest identifiers while they are of the receiver-code type. Identifiers are programmed through a byte-wide register port that is written synchronously and read combinationally.

Codeword bits are numbered 1 to 32 from the MSB (`cw_data_i[31]` is bit 1). The layout is as follows:
- Bit 1 is the flag (0 = address).
- Bits 2 to 19 (`cw_data_i[30:13]`) are the pattern.
- Bits 20 and 21 are function bits.
- Bits 22 to 31 are check bits.
- Bit 32 (`cw_data_i[0]`) makes the parity of the whole word even.

Top module: `addr_cw_matcher`

## Requirements
- R1: After reset, `hit_o` and `hit_idx_o` are 0, every register byte reads 0 except the control register, and the control register reads 8'h01.
- R2: Entry e occupies byte addresses 4e to 4e+2. Offset 0 holds pattern bits 2..9, with codeword bit 2 in D7. Offset 1 holds bits 10..17. Offset 2 holds the following fields: bits 18 and 19 in D7 and D6, frame bits in D5..D3 (D5 most significant), the type in D2 (1 = receiver code, 0 = sync word), and the enable in D1 (1 = on). Offsets 0 and 1 read back as written. Offset 2 reads back as written, except that D0 always reads 0.
- R3: Offset 3 of each entry (address 4e+3) is read-only and reads 8'h00. Writes to it change no register.
- R4: A codeword with flag bit `cw_data_i[31]` = 1 never produces a hit.
- R5: A codeword produces a hit only when `cw_synd_ok_i` is 1 and the XOR of all 32 bits is 0.
- R6: An enabled sync-word entry matches when `cw_data_i[30:13]` equals its 18 stored bits, whatever the value of `frame_slot_i`.
- R7: An enabled receiver-code entry matches only when its 18 bits are equal and `frame_slot_i` equals its stored frame bits.
- R8: An entry whose enable bit is 0 never matches.
- R9: The control register is at address 16. Only its D0 is stored, and it reads back in D0 with the other bits 0. While D0 is 0, entries 0 and 1 do not match when their type is receiver code. Their sync-word matching is unaffected, and so are entries 2 and 3.
- R10: A codeword presented with `cw_valid_i` high gives `hit_o` high on the next clock for exactly one cycle, unless another valid codeword follows. `hit_idx_o` then carries the lowest matching entry index. Without `cw_valid_i`, there is no hit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset, released synchronously inside |
| cw_valid_i | input | 1 | Codeword strobe |
| cw_data_i | input | 32 | Codeword, bit 1 in the MSB |
| cw_synd_ok_i | input | 1 | Upstream syndrome check passed |
| frame_slot_i | input | 3 | Frame slot index of the codeword within its batch |
| cfg_we_i | input | 1 | Register write enable |
| cfg_addr_i | input | 5 | Register byte address |
| cfg_wdata_i | input | 8 | Register write data |
| cfg_rdata_o | output | 8 | Register read data, combinational from `cfg_addr_i` |
| hit_o | output | 1 | Match strobe |
| hit_idx_o | output | 2 | Index of the lowest matching entry |

## Verification
A corrupted stored identifier shows on `cfg_rdata_o` as soon as its address is read. It also shows as a missing or extra hit one clock after the next codeword that carries that pattern. A decode fault in the register port, for example a write at offset 3 landing in offset 2, appears in the next readback of the neighbouring byte. A wrong priority or gating state appears as a wrong `hit_idx_o` or `hit_o` one clock after a codeword that matches several entries. The bench sweeps every combination of type and enable bits over all four entries, both control values and all eight slots, so that each of these states is reached.

// File: rtl/amatch_pkg.sv
package amatch_pkg;

  // Field widths fixed by the codeword format
  localparam int ID_W = 18;
  localparam int FR_W = 3;

  typedef struct packed {
    logic [ID_W-1:0] id;     // codeword bits 2..19, bit 2 at the MSB
    logic [FR_W-1:0] frame;  // frame slot for receiver-code entries
    logic            rcv;    // 1 = receiver code, 0 = sync word
    logic            en;     // entry enable
  } ident_t;

endpackage

// File: rtl/amatch_regs.sv
module amatch_regs
  import amatch_pkg::*;
#(
  parameter int NUM_ENT = 4,
  parameter int ADDR_W  = 5
) (
  input  logic                      clk_i,
  input  logic                      rst_n,
  input  logic                      we_i,
  input  logic [ADDR_W-1:0]         addr_i,
  input  logic [7:0]                wdata_i,
  output logic [7:0]                rdata_o,
  output ident_t [NUM_ENT-1:0]      ent_o,
  output logic                      rc_low_en_o
);

  localparam int ENT_IDX_W = ADDR_W - 2;
  localparam int CTRL_ADDR = NUM_ENT * 4;

  logic [1:0]           offs;
  logic [ENT_IDX_W-1:0] ent_sel;
  logic                 in_bank;
  logic                 is_ctrl;
  logic [7:0]           rd_byte [NUM_ENT];

  assign offs    = addr_i[1:0];
  assign ent_sel = addr_i[ADDR_W-1:2];
  assign in_bank = (int'(addr_i) < CTRL_ADDR);
  assign is_ctrl = (addr_i == ADDR_W'(CTRL_ADDR));

  // Control register: D0 enables receiver-code matching on the two lowest entries
  logic ctrl_q, ctrl_d, ctrl_en;

  always_comb begin
    ctrl_en = we_i && is_ctrl;
    ctrl_d  = wdata_i[0];
  end

  always_ff @(posedge clk_i or negedge rst_n) begin
    if (!rst_n)       ctrl_q <= 1'b1;
    else if (ctrl_en) ctrl_q <= ctrl_d;
  end

  assign rc_low_en_o = ctrl_q;

  for (genvar g = 0; g < NUM_ENT; g++) begin : g_ent
    logic [7:0] b0_q, b1_q;
    logic [7:1] b2_q;
    logic       hit_ent;
    logic       b0_en, b1_en, b2_en;

    always_comb begin
      hit_ent = we_i && in_bank && (ent_sel == ENT_IDX_W'(g));
      b0_en   = hit_ent && (offs == 2'd0);
      b1_en   = hit_ent && (offs == 2'd1);
      b2_en   = hit_ent && (offs == 2'd2);
    end

    always_ff @(posedge clk_i or negedge rst_n) begin
      if (!rst_n) begin
        b0_q <= '0;
        b1_q <= '0;
        b2_q <= '0;
      end else begin
        if (b0_en) b0_q <= wdata_i;
        if (b1_en) b1_q <= wdata_i;
        if (b2_en) b2_q <= wdata_i[7:1];
      end
    end

    assign ent_o[g].id    = {b0_q, b1_q, b2_q[7:6]};
    assign ent_o[g].frame = b2_q[5:3];
    assign ent_o[g].rcv   = b2_q[2];
    assign ent_o[g].en    = b2_q[1];

    always_comb begin
      unique case (offs)
        2'd0:    rd_byte[g] = b0_q;
        2'd1:    rd_byte[g] = b1_q;
        2'd2:    rd_byte[g] = {b2_q, 1'b0};
        default: rd_byte[g] = 8'h00;
      endcase
    end
  end

  always_comb begin
    rdata_o = 8'h00;
    if (is_ctrl) begin
      rdata_o = {7'b0, ctrl_q};
    end else if (in_bank) begin
      for (int i = 0; i < NUM_ENT; i++) begin
        if (ent_sel == ENT_IDX_W'(i)) rdata_o = rd_byte[i];
      end
    end
  end

  AST_RSVD_READS_ZERO: assert property (@(posedge clk_i) disable iff (!rst_n)
    (in_bank && offs == 2'd2) |-> (rdata_o[0] == 1'b0)); // R2

  AST_SPARE_READS_ZERO: assert property (@(posedge clk_i) disable iff (!rst_n)
    (in_bank && offs == 2'd3) |-> (rdata_o == 8'h00)); // R3

  AST_CTRL_HOLDS: assert property (@(posedge clk_i) disable iff (!rst_n)
    !(we_i && is_ctrl) |=> $stable(ctrl_q)); // R9

endmodule

// File: rtl/amatch_cmp.sv
module amatch_cmp
  import amatch_pkg::*;
#(
  parameter int NUM_ENT      = 4,
  parameter int RC_GATE_CNT  = 2
) (
  input  ident_t [NUM_ENT-1:0] ent_i,
  input  logic [ID_W-1:0]      cw_id_i,
  input  logic [FR_W-1:0]      slot_i,
  input  logic                 rc_low_en_i,
  output logic [NUM_ENT-1:0]   match_o
);

  for (genvar g = 0; g < NUM_ENT; g++) begin : g_cmp
    localparam bit GATEABLE = (g < RC_GATE_CNT);
    logic id_eq, slot_ok, gated;

    always_comb begin
      id_eq      = (ent_i[g].id == cw_id_i);
      slot_ok    = !ent_i[g].rcv || (ent_i[g].frame == slot_i);
      gated      = GATEABLE && ent_i[g].rcv && !rc_low_en_i;
      match_o[g] = ent_i[g].en && !gated && id_eq && slot_ok;
    end
  end

endmodule

// File: rtl/amatch_hitreg.sv
module amatch_hitreg #(
  parameter int NUM_ENT = 4,
  parameter int IDX_W   = 2
) (
  input  logic               clk_i,
  input  logic               rst_n,
  input  logic               word_ok_i,
  input  logic [NUM_ENT-1:0] match_i,
  output logic               hit_o,
  output logic [IDX_W-1:0]   idx_o
);

  logic             any_d, hit_d, idx_en;
  logic [IDX_W-1:0] idx_d;
  logic             hit_q;
  logic [IDX_W-1:0] idx_q;

  always_comb begin
    idx_d = '0;
    any_d = 1'b0;
    for (int i = NUM_ENT - 1; i >= 0; i--) begin
      if (match_i[i]) begin
        idx_d = IDX_W'(i);
        any_d = 1'b1;
      end
    end
    hit_d  = word_ok_i && any_d;
    idx_en = hit_d;
  end

  always_ff @(posedge clk_i or negedge rst_n) begin
    if (!rst_n) begin
      hit_q <= 1'b0;
      idx_q <= '0;
    end else begin
      hit_q <= hit_d;
      if (idx_en) idx_q <= idx_d;
    end
  end

  assign hit_o = hit_q;
  assign idx_o = idx_q;

  AST_IDX_MATCHED: assert property (@(posedge clk_i) disable iff (!rst_n)
    hit_q |-> ((($past(match_i) >> idx_q) & NUM_ENT'(1)) != '0)); // R10

  AST_IDX_LOWEST: assert property (@(posedge clk_i) disable iff (!rst_n)
    hit_q |-> (($past(match_i) & ((NUM_ENT'(1) << idx_q) - NUM_ENT'(1))) == '0)); // R10

  AST_IDX_STICKY: assert property (@(posedge clk_i) disable iff (!rst_n)
    !hit_q |-> (idx_q == $past(idx_q))); // R10

endmodule

// File: rtl/addr_cw_matcher.sv
module addr_cw_matcher
  import amatch_pkg::*;
#(
  parameter  int NUM_ENT = 4,
  parameter  int CW_W    = 32,
  localparam int ADDR_W  = $clog2(NUM_ENT * 4 + 1),
  localparam int IDX_W   = $clog2(NUM_ENT)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              cw_valid_i,
  input  logic [CW_W-1:0]   cw_data_i,
  input  logic              cw_synd_ok_i,
  input  logic [FR_W-1:0]   frame_slot_i,
  input  logic              cfg_we_i,
  input  logic [ADDR_W-1:0] cfg_addr_i,
  input  logic [7:0]        cfg_wdata_i,
  output logic [7:0]        cfg_rdata_o,
  output logic              hit_o,
  output logic [IDX_W-1:0]  hit_idx_o
);

  // Reset: asserted asynchronously, released on a clock edge
  logic [1:0] rst_sync_q;
  logic       rst_n;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) rst_sync_q <= 2'b00;
    else         rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_n = rst_sync_q[1];

  ident_t [NUM_ENT-1:0] ent;
  logic                 rc_low_en;
  logic [NUM_ENT-1:0]   match_vec;
  logic                 is_addr, parity_ok, word_ok;
  logic [ID_W-1:0]      cw_id;

  always_comb begin
    is_addr   = !cw_data_i[CW_W-1];
    parity_ok = !(^cw_data_i);
    cw_id     = cw_data_i[CW_W-2 -: ID_W];
    word_ok   = cw_valid_i && is_addr && parity_ok && cw_synd_ok_i;
  end

  amatch_regs #(.NUM_ENT(NUM_ENT), .ADDR_W(ADDR_W)) i_regs (
    .clk_i       (clk_i),
    .rst_n       (rst_n),
    .we_i        (cfg_we_i),
    .addr_i      (cfg_addr_i),
    .wdata_i     (cfg_wdata_i),
    .rdata_o     (cfg_rdata_o),
    .ent_o       (ent),
    .rc_low_en_o (rc_low_en)
  );

  amatch_cmp #(.NUM_ENT(NUM_ENT), .RC_GATE_CNT(2)) i_cmp (
    .ent_i       (ent),
    .cw_id_i     (cw_id),
    .slot_i      (frame_slot_i),
    .rc_low_en_i (rc_low_en),
    .match_o     (match_vec)
  );

  amatch_hitreg #(.NUM_ENT(NUM_ENT), .IDX_W(IDX_W)) i_hit (
    .clk_i     (clk_i),
    .rst_n     (rst_n),
    .word_ok_i (word_ok),
    .match_i   (match_vec),
    .hit_o     (hit_o),
    .idx_o     (hit_idx_o)
  );

  AST_HIT_NEEDS_VALID: assert property (@(posedge clk_i) disable iff (!rst_n)
    hit_o |-> $past(cw_valid_i)); // R10

  AST_HIT_ADDR_ONLY: assert property (@(posedge clk_i) disable iff (!rst_n)
    hit_o |-> !$past(cw_data_i[CW_W-1])); // R4

  AST_HIT_CHECKED_WORD: assert property (@(posedge clk_i) disable iff (!rst_n)
    hit_o |-> ($past(cw_synd_ok_i) && !(^$past(cw_data_i)))); // R5

  AST_DISABLED_SILENT: assert property (@(posedge clk_i) disable iff (!rst_n)
    (ent == '0) |=> !hit_o); // R8

endmodule

// File: tb/test_addr_cw_matcher.sv
module test_addr_cw_matcher;

  localparam int CLK_PERIOD = 10;
  localparam int WATCHDOG   = 150000;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cw_valid = 1'b0;
  logic [31:0] cw_data = '0;
  logic        synd_ok = 1'b0;
  logic [2:0]  slot = '0;
  logic        we = 1'b0;
  logic [4:0]  addr = '0;
  logic [7:0]  wdata = '0;
  logic [7:0]  rdata;
  logic        hit;
  logic [1:0]  hit_idx;

  int n_chk = 0;
  int n_bad = 0;
  bit timed_out = 1'b0;

  // Bench copy of what it has programmed
  logic [17:0] m_id [4];
  logic [2:0]  m_fr [4];
  logic        m_rc [4];
  logic        m_en [4];
  logic        m_ctrl;

  always #(CLK_PERIOD/2) clk = ~clk;

  addr_cw_matcher i_addr_cw_matcher (
    .clk_i        (clk),
    .rst_ni       (rst_n),
    .cw_valid_i   (cw_valid),
    .cw_data_i    (cw_data),
    .cw_synd_ok_i (synd_ok),
    .frame_slot_i (slot),
    .cfg_we_i     (we),
    .cfg_addr_i   (addr),
    .cfg_wdata_i  (wdata),
    .cfg_rdata_o  (rdata),
    .hit_o        (hit),
    .hit_idx_o    (hit_idx)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h at %0t", req, act, exp, $time);
    end
  endtask

  task automatic wr(input logic [4:0] a, input logic [7:0] d);
    @(negedge clk);
    we = 1'b1; addr = a; wdata = d;
    @(negedge clk);
    we = 1'b0;
  endtask

  task automatic rd_check(input string req, input logic [4:0] a, input logic [7:0] exp);
    @(negedge clk);
    addr = a;
    #1;
    check(req, {24'b0, rdata}, {24'b0, exp});
  endtask

  task automatic prog(input int e, input logic [17:0] id, input logic [2:0] fr,
                      input logic rc, input logic en);
    wr(5'(4*e),     id[17:10]);
    wr(5'(4*e + 1), id[9:2]);
    wr(5'(4*e + 2), {id[1:0], fr, rc, en, 1'b1});
    m_id[e] = id; m_fr[e] = fr; m_rc[e] = rc; m_en[e] = en;
  endtask

  task automatic set_ctrl(input logic v);
    wr(5'd16, {7'h55, v});
    m_ctrl = v;
  endtask

  // Flag in bit 31, pattern in 30:13, even overall parity in bit 0
  function automatic logic [31:0] mk_cw(input logic flag, input logic [17:0] id,
                                        input logic [11:0] rest);
    logic [31:0] w;
    w[31:1] = {flag, id, rest};
    w[0]    = ^w[31:1];
    return w;
  endfunction

  function automatic int exp_idx(input logic [17:0] id, input logic [2:0] s);
    for (int e = 0; e < 4; e++) begin
      if (m_en[e] && m_id[e] == id && (!m_rc[e] || m_fr[e] == s)
          && !(e < 2 && m_rc[e] && !m_ctrl))
        return e;
    end
    return -1;
  endfunction

  task automatic send(input string req, input logic [31:0] w, input logic ok,
                      input logic [2:0] s, input int exp);
    @(negedge clk);
    cw_valid = 1'b1; cw_data = w; synd_ok = ok; slot = s;
    @(negedge clk);
    cw_valid = 1'b0;
    cw_data  = ~w;
    check(req, {31'b0, hit}, {31'b0, exp >= 0});
    if (exp >= 0) check(req, {30'b0, hit_idx}, 32'(exp));
  endtask

  task automatic run_all();
    logic [17:0] ids [4];
    logic [7:0]  pat;
    logic [7:0]  expv;
    int          ex;

    // R1: reset state
    repeat (4) @(negedge clk);
    check("R1 hit", {31'b0, hit}, 32'd0);
    check("R1 idx", {30'b0, hit_idx}, 32'd0);
    for (int a = 0; a < 17; a++) rd_check("R1 regs", 5'(a), (a == 16) ? 8'h01 : 8'h00);

    // R2/R3: register readback, spare offset read-only
    for (int a = 0; a < 16; a++) wr(5'(a), 8'((a * 37 + 91) ^ 8'hA5));
    for (int a = 0; a < 16; a++) begin
      pat = 8'((a * 37 + 91) ^ 8'hA5);
      case (a % 4)
        0, 1:    expv = pat;
        2:       expv = pat & 8'hFE;
        default: expv = 8'h00;
      endcase
      rd_check((a % 4 == 3) ? "R3 spare" : "R2 readback", 5'(a), expv);
    end
    // R9: control register readback
    set_ctrl(1'b0);
    rd_check("R9 ctrl", 5'd16, 8'h00);
    set_ctrl(1'b1);
    rd_check("R9 ctrl", 5'd16, 8'h01);

    // R4/R5: rejected codeword kinds on an all-sync bank
    prog(0, 18'h2A5C3, 3'd1, 1'b0, 1'b1);
    prog(1, 18'h1F00E, 3'd4, 1'b0, 1'b1);
    prog(2, 18'h2A5C3, 3'd6, 1'b0, 1'b1);
    prog(3, 18'h1F00E, 3'd7, 1'b0, 1'b1);
    for (int s = 0; s < 8; s++) begin
      send("R4 message flag", mk_cw(1'b1, 18'h2A5C3, 12'h3C5), 1'b1, 3'(s), -1);
      send("R5 bad parity", mk_cw(1'b0, 18'h2A5C3, 12'h3C5) ^ 32'h1, 1'b1, 3'(s), -1);
      send("R5 syndrome", mk_cw(1'b0, 18'h1F00E, 12'h0F1), 1'b0, 3'(s), -1);
      send("R6 good word", mk_cw(1'b0, 18'h1F00E, 12'h0F1), 1'b1, 3'(s), 1);
    end

    // R10: strobe lasts one cycle, no hit without valid
    send("R10 hit", mk_cw(1'b0, 18'h2A5C3, 12'h000), 1'b1, 3'd2, 0);
    @(negedge clk);
    check("R10 one cycle", {31'b0, hit}, 32'd0);
    @(negedge clk);
    cw_data = mk_cw(1'b0, 18'h2A5C3, 12'h000); synd_ok = 1'b1;
    @(negedge clk);
    check("R10 no valid", {31'b0, hit}, 32'd0);

    // R6..R10 sweep: all type/enable combos, both control values, all slots
    ids[0] = 18'h2A5C3; ids[1] = 18'h1F00E; ids[2] = 18'h3FFFF; ids[3] = 18'h2A5C3 ^ 18'h20000;
    for (int cfg = 0; cfg < 512; cfg++) begin
      prog(0, 18'h2A5C3, 3'd1, cfg[0], cfg[1]);
      prog(1, 18'h1F00E, 3'd4, cfg[2], cfg[3]);
      prog(2, 18'h2A5C3, 3'd6, cfg[4], cfg[5]);
      prog(3, 18'h1F00E, 3'd7, cfg[6], cfg[7]);
      set_ctrl(cfg[8]);
      for (int s = 0; s < 8; s++) begin
        for (int t = 0; t < 4; t++) begin
          ex = exp_idx(ids[t], 3'(s));
          send("R6 R7 R8 R9 R10 sweep", mk_cw(1'b0, ids[t], 12'(cfg * 7 + s)), 1'b1, 3'(s), ex);
        end
      end
    end
  endtask

  initial begin
    m_ctrl = 1'b1;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    fork
      run_all();
      begin
        repeat (WATCHDOG) @(posedge clk);
        timed_out = 1'b1;
      end
    join_any
    disable fork;
    if (timed_out) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
    end
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

endmodule